// File: doc/BRIEF.md
# Pixel Pack, Expand and Merge Unit

This block is a SIMD formatting datapath for a graphics pipeline. It takes two 64-bit operands and a 64-bit graphics status word. It produces one 64-bit result in one of five ways:

- convert partitioned signed fixed-point lanes into saturated 8-bit or 16-bit pixels;
- widen 8-bit pixels into 16-bit fixed-point lanes;
- interleave the bytes of two 32-bit words.

The pack operations take a left-shift amount from a scale field in the status word. Results that are only 32 bits wide sit in the low half of the output, and the upper half is zero.

All arithmetic is combinational and the result is registered. Operations enter through a valid/ready input and leave through a valid/ready output. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next cycle with `out_valid` high.

`in_ready` is high whenever the output register is empty or is being drained in the same cycle. If the consumer holds `out_ready` low, the result and `out_valid` stay frozen and no new operation is taken. Register-file access, instruction decode and writes to the status word belong to neighbouring blocks.

Top module: `pxf_format_unit`

## Requirements
- R1: Operation code 0 (byte pack) works as follows.
  - The scale is status bits [6:3], four bits.
  - Each of the four signed 16-bit lanes of operand B is shifted left by the scale, then arithmetically shifted right by 7, then clamped to 0..255.
  - Lane i goes to result byte i, and result bits [63:32] are zero.
- R2: Operation code 1 (word pack with insert) works as follows.
  - The scale is status bits [7:3], five bits.
  - Each signed 32-bit word of operand B is shifted left by the scale, arithmetically shifted right by 23, and clamped to 0..255.
  - Result word w is operand A's word w shifted left by 8, with word w's packed byte in its lowest byte.
- R3: Operation code 2 (fixed pack) works as follows.
  - The scale is status bits [7:3].
  - Each signed 32-bit word of operand B is shifted left by the scale, arithmetically shifted right by 16, and saturated to -32768..32767.
  - Word w goes to result bits [16w+15:16w], and result bits [63:32] are zero.
- R4: Operation code 3 (expand) places byte k of operand B's low 32 bits, shifted left by 4, into result bits [16k+15:16k], zero-extended.
- R5: Operation code 4 (merge) interleaves the low 32 bits of the two operands. Result byte 2k is byte k of operand B, and result byte 2k+1 is byte k of operand A.
- R6: Operation codes 5, 6 and 7 produce an all-zero result and still raise `out_valid`.
- R7: An accepted operation shows its result with `out_valid` high on the following cycle. With `out_ready` held high and no new input, `out_valid` is high for exactly that one cycle.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold their values and `in_ready` is low.
- R9: While reset is active and after it is released, `out_valid` is low and `out_data` is zero until an operation is accepted.
- R10: Status bits outside the scale field of the selected operation have no effect on the result. For example, bit 7 does not affect the byte pack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted this cycle |
| in_op | input | 3 | Operation code (0..4 defined) |
| in_src_a | input | 64 | First operand |
| in_src_b | input | 64 | Second operand |
| in_status | input | 64 | Graphics status word carrying the scale field |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Formatted result |

## Verification
The bench builds the unit with its default parameters: 64-bit data, the scale field at bit 3, and shift points of 7, 23 and 16. With these values the full scale ranges of 0..15 and 0..31 are reachable, so randomized status words drive every lane into both clamp limits as well as the pass-through band.

Directed cases cover the following:
- the most negative and most positive lane values;
- status bits just above the 4-bit field, checked to have no effect on the byte pack;
- the three undefined operation codes;
- a back-pressure stall lasting several cycles.

// File: rtl/pxf_pkg.sv
package pxf_pkg;
  typedef enum logic [2:0] {
    OP_PACK8   = 3'd0,
    OP_PACK32  = 3'd1,
    OP_PACKFIX = 3'd2,
    OP_EXPAND  = 3'd3,
    OP_MERGE   = 3'd4
  } pxf_op_e;
endpackage

// File: rtl/pxf_sat_lane.sv
module pxf_sat_lane #(
  parameter int LANE_W     = 16,
  parameter int SCALE_W    = 4,
  parameter int FRAC       = 7,
  parameter int OUT_W      = 8,
  parameter bit SIGNED_OUT = 1'b0
) (
  input  logic [LANE_W-1:0]  lane,
  input  logic [SCALE_W-1:0] scale,
  output logic [OUT_W-1:0]   sat
);
  // wide enough that the largest left shift cannot overflow
  localparam int EXT_W = LANE_W + (1 << SCALE_W) - 1;
  localparam longint HI_L = SIGNED_OUT ? ((64'sd1 <<< (OUT_W - 1)) - 64'sd1)
                                       : ((64'sd1 <<< OUT_W) - 64'sd1);
  localparam longint LO_L = SIGNED_OUT ? (-(64'sd1 <<< (OUT_W - 1))) : 64'sd0;
  localparam logic signed [EXT_W-1:0] HI = EXT_W'(HI_L);
  localparam logic signed [EXT_W-1:0] LO = EXT_W'(LO_L);

  logic signed [EXT_W-1:0] ext;
  logic signed [EXT_W-1:0] scaled;
  logic signed [EXT_W-1:0] shr;

  assign ext    = {{(EXT_W - LANE_W){lane[LANE_W-1]}}, lane};
  assign scaled = ext <<< scale;
  assign shr    = scaled >>> FRAC;

  always_comb begin
    if (shr > HI)      sat = HI[OUT_W-1:0];
    else if (shr < LO) sat = LO[OUT_W-1:0];
    else               sat = shr[OUT_W-1:0];
  end
endmodule

// File: rtl/pxf_pack.sv
module pxf_pack #(
  parameter int DATA_W    = 64,
  parameter int SCALE_W16 = 4,
  parameter int SCALE_W32 = 5,
  parameter int FRAC16    = 7,
  parameter int FRAC32    = 23,
  parameter int FRACFIX   = 16
) (
  input  logic [DATA_W-1:0]    src_a,
  input  logic [DATA_W-1:0]    src_b,
  input  logic [SCALE_W16-1:0] scale16,
  input  logic [SCALE_W32-1:0] scale32,
  output logic [DATA_W-1:0]    pack8_res,
  output logic [DATA_W-1:0]    pack32_res,
  output logic [DATA_W-1:0]    packfix_res
);
  localparam int N16 = DATA_W / 16;
  localparam int N32 = DATA_W / 32;

  logic [N16*8-1:0]  pk8;
  logic [N32*16-1:0] pkfix;

  // four 16-bit lanes to unsigned bytes
  for (genvar i = 0; i < N16; i++) begin : g_lane16
    pxf_sat_lane #(
      .LANE_W(16), .SCALE_W(SCALE_W16), .FRAC(FRAC16),
      .OUT_W(8), .SIGNED_OUT(1'b0)
    ) u_sat (
      .lane (src_b[16*i +: 16]),
      .scale(scale16),
      .sat  (pk8[8*i +: 8])
    );
  end
  assign pack8_res = {{(DATA_W - N16*8){1'b0}}, pk8};

  // 32-bit lanes: byte pack with insertion and signed 16-bit pack
  for (genvar w = 0; w < N32; w++) begin : g_lane32
    logic [7:0] pbyte;
    pxf_sat_lane #(
      .LANE_W(32), .SCALE_W(SCALE_W32), .FRAC(FRAC32),
      .OUT_W(8), .SIGNED_OUT(1'b0)
    ) u_sat_b (
      .lane (src_b[32*w +: 32]),
      .scale(scale32),
      .sat  (pbyte)
    );
    pxf_sat_lane #(
      .LANE_W(32), .SCALE_W(SCALE_W32), .FRAC(FRACFIX),
      .OUT_W(16), .SIGNED_OUT(1'b1)
    ) u_sat_f (
      .lane (src_b[32*w +: 32]),
      .scale(scale32),
      .sat  (pkfix[16*w +: 16])
    );
    // word w of A moved up one byte, packed byte in its freed low byte
    assign pack32_res[32*w +: 32] = {src_a[32*w +: 24], pbyte};
  end
  assign packfix_res = {{(DATA_W - N32*16){1'b0}}, pkfix};
endmodule

// File: rtl/pxf_rearrange.sv
module pxf_rearrange #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] expand_res,
  output logic [DATA_W-1:0] merge_res
);
  localparam int NB = DATA_W / 16;  // bytes in the low half

  for (genvar k = 0; k < NB; k++) begin : g_byte
    assign expand_res[16*k +: 16]    = {4'b0000, src_b[8*k +: 8], 4'b0000};
    assign merge_res[16*k +: 8]      = src_b[8*k +: 8];
    assign merge_res[16*k + 8 +: 8]  = src_a[8*k +: 8];
  end
endmodule

// File: rtl/pxf_format_unit.sv
module pxf_format_unit #(
  parameter int DATA_W    = 64,
  parameter int SCALE_LSB = 3,
  parameter int SCALE_W16 = 4,
  parameter int SCALE_W32 = 5,
  parameter int FRAC16    = 7,
  parameter int FRAC32    = 23,
  parameter int FRACFIX   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_src_a,
  input  logic [DATA_W-1:0] in_src_b,
  input  logic [DATA_W-1:0] in_status,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  import pxf_pkg::*;

  logic [DATA_W-1:0] r_pack8, r_pack32, r_packfix, r_expand, r_merge;
  logic [DATA_W-1:0] sel;
  logic              in_fire;

  pxf_pack #(
    .DATA_W(DATA_W), .SCALE_W16(SCALE_W16), .SCALE_W32(SCALE_W32),
    .FRAC16(FRAC16), .FRAC32(FRAC32), .FRACFIX(FRACFIX)
  ) u_pack (
    .src_a      (in_src_a),
    .src_b      (in_src_b),
    .scale16    (in_status[SCALE_LSB +: SCALE_W16]),
    .scale32    (in_status[SCALE_LSB +: SCALE_W32]),
    .pack8_res  (r_pack8),
    .pack32_res (r_pack32),
    .packfix_res(r_packfix)
  );

  pxf_rearrange #(.DATA_W(DATA_W)) u_rearr (
    .src_a     (in_src_a),
    .src_b     (in_src_b),
    .expand_res(r_expand),
    .merge_res (r_merge)
  );

  always_comb begin
    case (in_op)
      OP_PACK8:   sel = r_pack8;
      OP_PACK32:  sel = r_pack32;
      OP_PACKFIX: sel = r_packfix;
      OP_EXPAND:  sel = r_expand;
      OP_MERGE:   sel = r_merge;
      default:    sel = '0;
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      out_data  <= sel;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> out_valid);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R6
  unknown_op_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && in_op > 3'd4) |=> (out_data == '0));
endmodule

// File: tb/pxf_format_unit_test.sv
`timescale 1ns/1ps
module pxf_format_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [63:0] in_src_a = '0, in_src_b = '0, in_status = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  pxf_format_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .in_status(in_status), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  function automatic logic [63:0] ref_result(input logic [2:0] op,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] g);
    logic [63:0] r;
    longint v;
    int sc;
    r = '0;
    case (op)
      3'd0: begin
        sc = int'(g[6:3]);
        for (int i = 0; i < 4; i++) begin
          v = longint'($signed(b[16*i +: 16]));
          v = (v <<< sc) >>> 7;
          if (v < 0) v = 0; else if (v > 255) v = 255;
          r[8*i +: 8] = v[7:0];
        end
      end
      3'd1: begin
        sc = int'(g[7:3]);
        r = (a << 8) & ~64'h000000ff_000000ff;
        for (int w = 0; w < 2; w++) begin
          v = longint'($signed(b[32*w +: 32]));
          v = (v <<< sc) >>> 23;
          if (v < 0) v = 0; else if (v > 255) v = 255;
          r[32*w +: 8] = r[32*w +: 8] | v[7:0];
        end
      end
      3'd2: begin
        sc = int'(g[7:3]);
        for (int w = 0; w < 2; w++) begin
          v = longint'($signed(b[32*w +: 32]));
          v = (v <<< sc) >>> 16;
          if (v < -32768) v = -32768; else if (v > 32767) v = 32767;
          r[16*w +: 16] = v[15:0];
        end
      end
      3'd3: for (int k = 0; k < 4; k++) r[16*k +: 16] = 16'(b[8*k +: 8]) << 4;
      3'd4: for (int k = 0; k < 4; k++) begin
        r[16*k +: 8]     = b[8*k +: 8];
        r[16*k + 8 +: 8] = a[8*k +: 8];
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // issue one operation and check its result one cycle later
  task automatic run_op(input string tag, input logic [2:0] op, input logic [63:0] a,
                        input logic [63:0] b, input logic [63:0] g, input logic [63:0] exp);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_op = op; in_src_a = a; in_src_b = b; in_status = g;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {63'd0, out_valid}, 64'd1);
    check(tag, out_data, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b, g, held;
    logic [2:0]  op;
    int unused_seed;
    unused_seed = $urandom(32'd20240611);

    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9 reset valid", {63'd0, out_valid}, 64'd0);
    check("R9 reset data", out_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 after reset valid", {63'd0, out_valid}, 64'd0);

    // R1 directed: lanes 0x0100,0x7fff,0x8000,0x0080 at scale 0
    run_op("R1 pack8 directed", 3'd0, 64'h0, 64'h0080_8000_7fff_0100, 64'h0,
           64'h0000_0000_0100_ff02);
    // R1 max scale saturates positives, clears negatives
    b = 64'h0001_ffff_0100_7fff; g = 64'd15 << 3;
    run_op("R1 pack8 scale15", 3'd0, 64'h0, b, g, ref_result(3'd0, 64'h0, b, g));
    // R10 status bit 7 and above ignored by byte pack
    g = (64'd2 << 3) | 64'hffff_ffff_ffff_ff87;
    g[6:3] = 4'd2;
    b = 64'h0040_0123_ff80_0011;
    run_op("R10 pack8 high status bits", 3'd0, 64'h0, b, g, ref_result(3'd0, 64'h0, b, 64'd2 << 3));
    // R10 bits below the field ignored by word pack
    b = 64'h0012_3456_0080_0000;
    run_op("R10 pack32 low status bits", 3'd1, 64'h1122_3344_5566_7788, b, 64'h7 | (64'd1 << 3),
           ref_result(3'd1, 64'h1122_3344_5566_7788, b, 64'd1 << 3));
    // R2 directed: word0 0x00800000>>23=1, word1 negative -> 0
    run_op("R2 pack32 directed", 3'd1, 64'h1122_3344_5566_7788, 64'h8000_0000_0080_0000, 64'h0,
           64'h2233_4400_6677_8801);
    // R3 directed: saturate both ends at max scale
    b = 64'h8000_0000_7fff_ffff; g = 64'd31 << 3;
    run_op("R3 packfix saturate", 3'd2, 64'h0, b, g, 64'h0000_0000_8000_7fff);
    run_op("R3 packfix plain", 3'd2, 64'h0, 64'hfffe_0000_0003_0000, 64'h0, 64'h0000_0000_fffe_0003);
    // R4 expand
    run_op("R4 expand", 3'd3, 64'h0, 64'hdead_beef_80ff_0102, 64'h0, 64'h0800_0ff0_0010_0020);
    // R5 merge
    run_op("R5 merge", 3'd4, 64'hffff_ffff_4433_2211, 64'heeee_eeee_ddcc_bbaa, 64'h0,
           64'h44dd_33cc_22bb_11aa);
    // R6 undefined codes
    for (int c = 5; c < 8; c++)
      run_op("R6 undefined op", 3'(c), 64'hffff_ffff_ffff_ffff, 64'h1234_5678_9abc_def0,
             64'hffff, 64'h0);

    // R7 one-cycle pulse
    run_op("R7 setup", 3'd4, 64'h1, 64'h2, 64'h0, 64'h0000_0000_0000_0102);
    @(negedge clk);
    check("R7 pulse ends", {63'd0, out_valid}, 64'd0);

    // R8 stall
    out_ready = 1'b0;
    run_op("R8 stall result", 3'd3, 64'h0, 64'h0000_0000_0403_0201, 64'h0, 64'h0040_0030_0020_0010);
    held = out_data;
    repeat (3) begin
      @(negedge clk);
      check("R8 held valid", {63'd0, out_valid}, 64'd1);
      check("R8 held data", out_data, held);
      check("R8 in_ready low", {63'd0, in_ready}, 64'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    check("R8 drained", {63'd0, out_valid}, 64'd0);

    // random mix over all codes, R1-R6 via reference
    for (int n = 0; n < 400; n++) begin
      op = 3'($urandom_range(0, 7));
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      g = {$urandom, $urandom};
      if (n % 5 == 0) b[15:0] = 16'h8000;
      run_op("R1..R6 random", op, a, b, g, ref_result(op, a, b, g));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule